// File: doc/BRIEF.md
# Prescaled Coincidence Trigger Supervisor

This block turns discriminated detector hits into a single event trigger. A rising edge on any detector input opens a window a programmable number of cycles long, and pairs of open windows form coincidence terms. One anticoincidence term needs S2M with CER absent. The two single inputs (cosmic and periodic clock) and a software request are also trigger sources. Every source except the software request passes through its own power-of-two prescaler. The sources that survive are ORed into one event trigger.

An event is gathered over one gate length after the first surviving source. At the end of that span the block sends a one-cycle trigger pulse and latches a 32-bit pattern word. The low six bits of the word record which raw inputs had open windows. The bits above them record which scaled sources took part in the event. The block then stays busy and ignores further sources until the readout side acknowledges. A source can be marked for auto-validation, and it then ends the gathering span at once. Configuration is a simple write port with an address and a data word.

Top module: `trig_supervisor`

## Requirements
- R1: After reset, trig_o=0, busy_o=0 and pattern_o=0. Every prescale setting is 0, the gate length is 14 and no source is auto-validated. The software request is therefore the only source that can fire.
- R2: The scaled source flags in pattern_o are: bit6 S2M and not CER, bit7 S2M and CER2, bit8 S2M and CER, bit9 S1 and CER, bit10 S1 and S2M, bit11 S0 and CER, bit12 S0 and S2M, bit13 S0 and S1, bit14 software, bit15 cosmic, bit16 clock. A pair term occurs when both of its windows are open in the same cycle.
- R3: A rising edge on an input opens a window of G cycles, where G is the gate setting. Two inputs whose edges are sampled d cycles apart coincide only when d < G.
- R4: A prescale setting of 0 blocks its source and a setting of 1 passes every occurrence. A setting n from 2 to 15 passes the first occurrence after the setting is written, then one occurrence in every 2^(n-1).
- R5: The anticoincidence term (bit6) fires on S2M when CER is not open. S2M and CER opening together give bit8 and not bit6.
- R6: Bit k of pattern_o (k=0..5) is set when input det_i[k] had an open window during the event, even if its scaled source did not take part. The input order is cosmic, clock, S0, S1, S2M, CER. CER2 is never recorded among these bits. Bits 31:17 always read zero.
- R7: Take a surviving source whose inputs were first sampled at edge e, with no auto-validation. trig_o is high after edge e+1+G, where G is the gate length, and again e is the edge that sampled the first input.
- R8: An auto-validated source raises trig_o after the edge that follows its passing.
- R9: trig_o lasts one cycle. busy_o rises with trig_o and stays high until ack_i is sampled. Sources arriving while busy_o is high are dropped, and pattern_o holds its value.
- R10: The software request (rising edge of sw_trig_i) is never prescaled and sets bit14.
- R11: Configuration writes use these addresses: 0 clock, 1 cosmic, 2 S2M and not CER, 3 S0 and S1, 4 S0 and S2M, 5 S0 and CER, 6 S1 and S2M, 7 S1 and CER, 8 S2M and CER, 9 S2M and CER2 (each a 4-bit setting); 10 gate length (data bits 7:0); 11 auto-validation mask, where data bit i matches pattern bit 6+i. Writing a prescale setting clears that channel's counter.
- R12: All sources that pass during one gathering span are flagged together in one pattern word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one cycle per gate unit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| det_i | input | 6 | Discriminated inputs: cosmic, clock, S0, S1, S2M, CER |
| cer2_i | input | 1 | Second CER discriminator level |
| sw_trig_i | input | 1 | Software trigger request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration address |
| cfg_wdata_i | input | 16 | Configuration write data |
| ack_i | input | 1 | Readout acknowledge |
| trig_o | output | 1 | Event trigger pulse |
| busy_o | output | 1 | Event latched, waiting for acknowledge |
| pattern_o | output | 32 | Latched pattern word |

## Verification
A stale prescale counter shows as a missing or extra trigger on the first occurrence after a setting is written. A window counter that is off by one moves the edge-separation limit of a coincidence by one cycle, and it also moves the trigger latency by the same amount. Such a fault is visible within one event. A gathering counter in the wrong state shifts trig_o away from edge e+1+G, or drops raw and scaled bits that arrive late in the span. A fault in the busy logic shows as a second trigger before ack_i.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int NUM_RAW = 6;
  localparam int NUM_WIN = NUM_RAW + 1;  // raw inputs plus second CER level
  localparam int NUM_SRC = 11;
  localparam int NUM_PS  = 10;

  // window indices
  localparam int W_COSMIC = 0;
  localparam int W_CLK    = 1;
  localparam int W_S0     = 2;
  localparam int W_S1     = 3;
  localparam int W_S2M    = 4;
  localparam int W_CER    = 5;
  localparam int W_CER2   = 6;

  // scaled source indices (pattern bit = NUM_RAW + index)
  localparam int S_S2M_NCER = 0;
  localparam int S_S2M_CER2 = 1;
  localparam int S_S2M_CER  = 2;
  localparam int S_S1_CER   = 3;
  localparam int S_S1_S2M   = 4;
  localparam int S_S0_CER   = 5;
  localparam int S_S0_S2M   = 6;
  localparam int S_S0_S1    = 7;
  localparam int S_SW       = 8;
  localparam int S_COSMIC   = 9;
  localparam int S_CLK      = 10;

  localparam int ADDR_GATE = NUM_PS;
  localparam int ADDR_AUTO = NUM_PS + 1;

  typedef enum logic [1:0] {EV_IDLE, EV_COLLECT, EV_BUSY} ev_state_e;

  // prescale channel serving each source; -1 means unscaled
  function automatic int src_ps_chan(input int src);
    case (src)
      S_S2M_NCER: return 2;
      S_S2M_CER2: return 9;
      S_S2M_CER:  return 8;
      S_S1_CER:   return 7;
      S_S1_S2M:   return 6;
      S_S0_CER:   return 5;
      S_S0_S2M:   return 4;
      S_S0_S1:    return 3;
      S_COSMIC:   return 1;
      S_CLK:      return 0;
      default:    return -1;
    endcase
  endfunction
endpackage

// File: rtl/trig_window.sv
module trig_window #(
  parameter int GATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_i,
  input  logic [GATE_W-1:0] gate_i,
  output logic              open_o
);
  logic              in_q;
  logic [GATE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      in_q <= in_i;
      if (in_i && !in_q)   cnt_q <= gate_i;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign open_o = (cnt_q != '0);
endmodule

// File: rtl/trig_prescaler.sv
module trig_prescaler #(
  parameter int PS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PS_W-1:0] setting_i,
  input  logic            clear_i,
  input  logic            occ_i,
  output logic            pass_o
);
  localparam int DIV_W = (2 ** PS_W) - 2;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] reload;
  logic [DIV_W:0]   span;
  logic [DIV_W:0]   span_m1;
  logic             enabled;

  assign enabled = (setting_i != '0);

  always_comb begin
    span    = {{DIV_W{1'b0}}, 1'b1} << (setting_i - 1'b1);
    span_m1 = span - 1'b1;
    reload  = (setting_i <= PS_W'(1)) ? '0 : span_m1[DIV_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (occ_i && enabled) begin
      if (cnt_q == '0) cnt_q <= reload;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pass_o = occ_i && enabled && (cnt_q == '0);
endmodule

// File: rtl/trig_event_fsm.sv
module trig_event_fsm
  import trig_pkg::*;
#(
  parameter int GATE_W = 8,
  parameter int PAT_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_RAW-1:0] raw_i,
  input  logic [NUM_SRC-1:0] pass_i,
  input  logic [NUM_SRC-1:0] auto_i,
  input  logic [GATE_W-1:0]  gate_i,
  input  logic               ack_i,
  output logic               trig_o,
  output logic               busy_o,
  output logic [PAT_W-1:0]   pattern_o
);
  ev_state_e          state_q;
  logic [GATE_W-1:0]  cnt_q;
  logic [NUM_SRC-1:0] src_acc_q, src_nxt;
  logic [NUM_RAW-1:0] raw_acc_q, raw_nxt;
  logic               auto_hit, span_done;

  function automatic logic [PAT_W-1:0] pack(input logic [NUM_SRC-1:0] src,
                                            input logic [NUM_RAW-1:0] raw);
    logic [PAT_W-1:0] w;
    w = '0;
    w[NUM_RAW-1:0]       = raw;
    w[NUM_RAW+:NUM_SRC]  = src;
    return w;
  endfunction

  assign src_nxt   = src_acc_q | pass_i;
  assign raw_nxt   = raw_acc_q | raw_i;
  assign auto_hit  = |(pass_i & auto_i);
  assign span_done = (cnt_q <= GATE_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= EV_IDLE;
      cnt_q     <= '0;
      src_acc_q <= '0;
      raw_acc_q <= '0;
      trig_o    <= 1'b0;
      pattern_o <= '0;
    end else begin
      trig_o <= 1'b0;
      unique case (state_q)
        EV_IDLE: begin
          if (|pass_i) begin
            if (auto_hit) begin
              trig_o    <= 1'b1;
              pattern_o <= pack(pass_i, raw_i);
              state_q   <= EV_BUSY;
            end else begin
              cnt_q     <= gate_i;
              src_acc_q <= pass_i;
              raw_acc_q <= raw_i;
              state_q   <= EV_COLLECT;
            end
          end
        end
        EV_COLLECT: begin
          if (auto_hit || span_done) begin
            trig_o    <= 1'b1;
            pattern_o <= pack(src_nxt, raw_nxt);
            state_q   <= EV_BUSY;
          end else begin
            cnt_q     <= cnt_q - 1'b1;
            src_acc_q <= src_nxt;
            raw_acc_q <= raw_nxt;
          end
        end
        EV_BUSY: begin
          if (ack_i) state_q <= EV_IDLE;
        end
        default: state_q <= EV_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == EV_BUSY);
endmodule

// File: rtl/trig_supervisor.sv
module trig_supervisor
  import trig_pkg::*;
#(
  parameter int GATE_W   = 8,
  parameter int PS_W     = 4,
  parameter int CFG_AW   = 4,
  parameter int CFG_DW   = 16,
  parameter int PAT_W    = 32,
  parameter int GATE_RST = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_RAW-1:0] det_i,
  input  logic               cer2_i,
  input  logic               sw_trig_i,
  input  logic               cfg_we_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [CFG_DW-1:0]  cfg_wdata_i,
  input  logic               ack_i,
  output logic               trig_o,
  output logic               busy_o,
  output logic [PAT_W-1:0]   pattern_o
);
  logic [PS_W-1:0]    ps_set [NUM_PS];
  logic [NUM_PS-1:0]  ps_clr;
  logic [GATE_W-1:0]  gate_q;
  logic [NUM_SRC-1:0] auto_q;
  logic [NUM_WIN-1:0] win_in, win_open;
  logic               sw_q;
  logic [NUM_SRC-1:0] lvl, lvl_q, occ, pass;

  // configuration registers
  for (genvar k = 0; k < NUM_PS; k++) begin : g_ps_reg
    assign ps_clr[k] = cfg_we_i && (cfg_addr_i == CFG_AW'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ps_set[k] <= '0;
      else if (ps_clr[k]) ps_set[k] <= cfg_wdata_i[PS_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= GATE_W'(GATE_RST);
      auto_q <= '0;
    end else if (cfg_we_i) begin
      if (cfg_addr_i == CFG_AW'(ADDR_GATE)) gate_q <= cfg_wdata_i[GATE_W-1:0];
      if (cfg_addr_i == CFG_AW'(ADDR_AUTO)) auto_q <= cfg_wdata_i[NUM_SRC-1:0];
    end
  end

  // coincidence windows
  assign win_in = {cer2_i, det_i};

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    trig_window #(.GATE_W(GATE_W)) u_win (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (win_in[w]),
      .gate_i (gate_q),
      .open_o (win_open[w])
    );
  end

  // source levels
  always_comb begin
    lvl             = '0;
    lvl[S_S2M_NCER] = win_open[W_S2M] && !win_open[W_CER];
    lvl[S_S2M_CER2] = win_open[W_S2M] && win_open[W_CER2];
    lvl[S_S2M_CER]  = win_open[W_S2M] && win_open[W_CER];
    lvl[S_S1_CER]   = win_open[W_S1]  && win_open[W_CER];
    lvl[S_S1_S2M]   = win_open[W_S1]  && win_open[W_S2M];
    lvl[S_S0_CER]   = win_open[W_S0]  && win_open[W_CER];
    lvl[S_S0_S2M]   = win_open[W_S0]  && win_open[W_S2M];
    lvl[S_S0_S1]    = win_open[W_S0]  && win_open[W_S1];
    lvl[S_SW]       = sw_q;
    lvl[S_COSMIC]   = win_open[W_COSMIC];
    lvl[S_CLK]      = win_open[W_CLK];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= 1'b0;
      lvl_q <= '0;
    end else begin
      sw_q  <= sw_trig_i;
      lvl_q <= lvl;
    end
  end

  assign occ = lvl & ~lvl_q;

  // per-source prescaling
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int CH = src_ps_chan(s);
    if (CH < 0) begin : g_direct
      assign pass[s] = occ[s];
    end else begin : g_scaled
      trig_prescaler #(.PS_W(PS_W)) u_ps (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .setting_i (ps_set[CH]),
        .clear_i   (ps_clr[CH]),
        .occ_i     (occ[s]),
        .pass_o    (pass[s])
      );
    end
  end

  trig_event_fsm #(.GATE_W(GATE_W), .PAT_W(PAT_W)) u_ev (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_i     (win_open[NUM_RAW-1:0]),
    .pass_i    (pass),
    .auto_i    (auto_q),
    .gate_i    (gate_q),
    .ack_i     (ack_i),
    .trig_o    (trig_o),
    .busy_o    (busy_o),
    .pattern_o (pattern_o)
  );
endmodule

// File: rtl/trig_supervisor_chk.sv
module trig_supervisor_chk
  import trig_pkg::*;
#(
  parameter int PAT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             trig_o,
  input logic             busy_o,
  input logic [PAT_W-1:0] pattern_o
);
  // R9
  trig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  // R9
  trig_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> busy_o);

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ack_i) |=> busy_o);

  // R9
  pattern_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !trig_o) |-> $stable(pattern_o));

  // R9
  no_trig_from_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !$past(busy_o));

  // R12
  trig_has_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (pattern_o[NUM_RAW+:NUM_SRC] != '0));

  // R6
  pattern_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pattern_o[PAT_W-1:NUM_RAW+NUM_SRC] == '0);
endmodule

bind trig_supervisor trig_supervisor_chk #(.PAT_W(PAT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ack_i     (ack_i),
  .trig_o    (trig_o),
  .busy_o    (busy_o),
  .pattern_o (pattern_o)
);

// File: tb/tb_trig_supervisor.sv
`timescale 1ns/1ps
module tb_trig_supervisor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  stim = '0;  // 0 cosmic,1 clock,2 S0,3 S1,4 S2M,5 CER,6 CER2,7 sw
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        ack = 1'b0;
  logic        trig, busy;
  logic [31:0] pattern;

  trig_supervisor dut (
    .clk_i(clk), .rst_ni(rst_n), .det_i(stim[5:0]), .cer2_i(stim[6]),
    .sw_trig_i(stim[7]), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .ack_i(ack), .trig_o(trig), .busy_o(busy),
    .pattern_o(pattern)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [31:0] pat;
    int          lat;
    int          t0;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0, total = 0, bad = 0, n_trig = 0, t_last = 0, gate = 14;
  bit   done = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every trigger
  always @(negedge clk) begin
    if (rst_n && trig) begin
      n_trig++;
      if (q.size() == 0) begin
        chk(0, "R9", "unexpected trigger, pattern", pattern, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(pattern == e.pat, e.req, "pattern", pattern, e.pat);
        chk((cyc - e.t0) == e.lat, e.req, "latency", cyc - e.t0, e.lat);
      end
    end
  end

  task automatic cfg(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr == 10) gate = data;
  endtask

  task automatic pulse(input logic [7:0] a);
    @(negedge clk);
    stim = a; t_last = cyc;
    @(negedge clk);
    stim = '0;
  endtask

  // a at negedge N, b at negedge N+d
  task automatic hit2(input logic [7:0] a, input logic [7:0] b, input int d);
    @(negedge clk);
    stim = a; t_last = cyc;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      stim = (i == d - 1) ? b : 8'h00;
    end
    @(negedge clk);
    stim = '0;
  endtask

  task automatic push(input logic [31:0] pat, input int lat, input string req);
    exp_t e;
    e.pat = pat; e.lat = lat; e.t0 = t_last; e.req = req;
    q.push_back(e);
  endtask

  task automatic settle();
    repeat (gate + 6) @(negedge clk);
  endtask

  task automatic wait_event(input string req);
    int n;
    n = 0;
    while (q.size() != 0 && n < 80) begin
      @(negedge clk);
      n++;
    end
    chk(q.size() == 0, req, "trigger missing, queued", q.size(), 0);
    q.delete();
    chk(busy == 1'b1, "R9", "busy after event", busy, 1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk(busy == 1'b0, "R9", "busy after ack", busy, 0);
    settle();
  endtask

  task automatic expect_none(input logic [7:0] a, input string req);
    int n0;
    n0 = n_trig;
    pulse(a);
    settle();
    chk(n_trig == n0, req, "no trigger expected, count", n_trig - n0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(trig == 1'b0, "R1", "trig_o", trig, 0);
    chk(busy == 1'b0, "R1", "busy_o", busy, 0);
    chk(pattern == 32'h0, "R1", "pattern_o", pattern, 0);

    // R1 R10 software trigger passes with default gate 14
    pulse(8'h80); push(32'h4000, 16, "R10");
    wait_event("R10");
    cfg(10, 4);
    // R7 latency G+2
    pulse(8'h80); push(32'h4000, 6, "R7");
    wait_event("R7");

    // R9 sources dropped while busy
    pulse(8'h80); push(32'h4000, 6, "R9");
    while (q.size() != 0) @(negedge clk);
    n0 = n_trig;
    pulse(8'h80);
    repeat (12) @(negedge clk);
    chk(n_trig == n0, "R9", "trigger while busy", n_trig - n0, 0);
    chk(busy == 1'b1, "R9", "busy held", busy, 1);
    chk(pattern == 32'h4000, "R9", "pattern held", pattern, 32'h4000);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    repeat (12) @(negedge clk);
    chk(n_trig == n0, "R9", "dropped source later", n_trig - n0, 0);

    // R8 auto-validated software source
    cfg(11, 16'h0100);
    pulse(8'h80); push(32'h4000, 2, "R8");
    wait_event("R8");
    cfg(11, 0);

    // R4 setting 0 blocks S0&S1
    expect_none(8'h0C, "R4");
    // R2 R4 R11 setting 1 on address 3 passes every occurrence
    cfg(3, 1);
    pulse(8'h0C); push(32'h200C, 6, "R2");
    wait_event("R2");
    pulse(8'h0C); push(32'h200C, 6, "R4");
    wait_event("R4");

    // R3 edges 3 apart with G=4 coincide, 4 apart do not
    hit2(8'h04, 8'h08, 3); push(32'h200C, 9, "R3");
    wait_event("R3");
    n0 = n_trig;
    hit2(8'h04, 8'h08, 4);
    settle();
    chk(n_trig == n0, "R3", "separated edges", n_trig - n0, 0);

    // R6 CER recorded though its sources blocked, CER2 not recorded
    hit2(8'h0C, 8'h60, 1); push(32'h202C, 6, "R6");
    wait_event("R6");

    // R12 three pair terms in one event
    cfg(4, 1); cfg(6, 1);
    pulse(8'h1C); push(32'h341C, 6, "R12");
    wait_event("R12");
    cfg(3, 0); cfg(4, 0); cfg(6, 0);

    // R5 anticoincidence
    cfg(2, 1); cfg(8, 1);
    pulse(8'h10); push(32'h0050, 6, "R5");
    wait_event("R5");
    pulse(8'h30); push(32'h0130, 6, "R5");
    wait_event("R5");

    // R2 S2M with CER2 on address 9
    cfg(2, 0); cfg(9, 1);
    pulse(8'h50); push(32'h0090, 6, "R2");
    wait_event("R2");
    cfg(9, 0); cfg(8, 0);

    // R11 cosmic on address 1, clock on address 0
    cfg(1, 1);
    pulse(8'h01); push(32'h8001, 6, "R11");
    wait_event("R11");
    cfg(0, 1);
    pulse(8'h02); push(32'h10002, 6, "R11");
    wait_event("R11");

    // R4 setting 3 on S1&CER: one in four, first after write passes
    cfg(7, 3);
    for (int k = 0; k < 6; k++) begin
      if (k % 4 == 0) begin
        pulse(8'h28); push(32'h0228, 6, "R4");
        wait_event("R4");
      end else begin
        expect_none(8'h28, "R4");
      end
    end
    // R11 rewrite clears counter
    cfg(7, 3);
    pulse(8'h28); push(32'h0228, 6, "R11");
    wait_event("R11");
    cfg(7, 0);

    // R3 shorter gate
    cfg(3, 1); cfg(10, 2);
    n0 = n_trig;
    hit2(8'h04, 8'h08, 2);
    settle();
    chk(n_trig == n0, "R3", "gate 2 edges 2 apart", n_trig - n0, 0);
    hit2(8'h04, 8'h08, 1); push(32'h200C, 5, "R3");
    wait_event("R3");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule